// File: doc/BRIEF.md
# Two-Phase Accumulator Processor

This block is a compact 16-bit processor built around a single accumulator. Alongside the accumulator it holds a program counter and an instruction register. One adder-based ALU serves every arithmetic need, including the program counter advance, so the design has no separate incrementer. Each instruction word carries a 4-bit operation code in its upper bits and a 12-bit operand address S in its lower bits.

A two-state control unit moves between an execute phase and a fetch phase. A data instruction uses one memory cycle in each phase. A jump performs its fetch inside the execute cycle, so it costs one cycle. The number of cycles an instruction takes therefore equals the number of memory accesses it makes.

The block connects to a single-port memory. The memory returns read data within the same cycle as the request and accepts a write at the clock edge that ends the request cycle. A halt opcode stops the machine and raises a halted flag, which stays high until reset.

Top module: `acc_cpu`

## Requirements
- R1: While `rst_n` is low, `mem_req`, `halted` and `mem_wdata` are 0. In the first cycle after release, the block issues a read (`mem_req`=1, `mem_rnw`=1) at address 0x000.
- R2: A fetch cycle reads at the program counter, loads the instruction register, sets the program counter to that address plus 1, and is always followed by an execute cycle. From reset release to `halted`, a program takes 2 + 2·(data instructions) + (jump instructions) clock edges, counting the halt instruction.
- R3: Opcode 0000 (load) copies memory word S into the accumulator.
- R4: Opcode 0010 (add) sets the accumulator to accumulator + M[S]. Opcode 0011 (subtract) sets it to accumulator − M[S]. Both are taken modulo 2^16.
- R5: Opcode 0001 (store) performs one write cycle (`mem_req`=1, `mem_rnw`=0) at address S with `mem_wdata` equal to the accumulator. In every other cycle, `mem_wdata` is 0.
- R6: Opcode 0100 (jump) reads its next instruction from S in the same cycle, and the instruction at the next sequential address is not executed.
- R7: Opcode 0101 jumps to S when accumulator bit 15 is 0, which includes a zero accumulator. Otherwise it reads the next sequential instruction. Either way it takes one cycle.
- R8: Opcode 0110 jumps to S when the accumulator is nonzero. Otherwise it reads the next sequential instruction. Either way it takes one cycle.
- R9: Opcode 0111, and any opcode from 1000 to 1111, halts the machine. From then until reset, `halted` is 1, `mem_req` is 0, and no memory word changes.
- R10: The program counter is 12 bits wide. A fetch at address 0xFFF continues at 0x000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | 12 | Memory address |
| mem_rdata | input | 16 | Memory read data, valid in the request cycle |
| mem_wdata | output | 16 | Memory write data, zero unless storing |
| mem_req | output | 1 | Memory access request |
| mem_rnw | output | 1 | 1 = read, 0 = write |
| halted | output | 1 | Machine stopped by a halt opcode |

## Verification
The read request appears at the ports in the same cycle its phase begins. Accumulator results and store writes take effect at the edge that closes the execute cycle. `halted` rises at the edge that closes the halt instruction's execute cycle. The bench counts clock edges from reset release until `halted` is high, sampling each edge at the following falling edge. It compares that count against the R2 formula, which fixes when every instruction completes, including the single-cycle jumps. It checks accumulator results through store writes into its memory model once the run ends, and checks the write-data port and the request line at every falling edge.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

  localparam int OP_W = 4;

  localparam logic [OP_W-1:0] OP_LDA = 4'b0000;
  localparam logic [OP_W-1:0] OP_STO = 4'b0001;
  localparam logic [OP_W-1:0] OP_ADD = 4'b0010;
  localparam logic [OP_W-1:0] OP_SUB = 4'b0011;
  localparam logic [OP_W-1:0] OP_JMP = 4'b0100;
  localparam logic [OP_W-1:0] OP_JGE = 4'b0101;
  localparam logic [OP_W-1:0] OP_JNE = 4'b0110;
  localparam logic [OP_W-1:0] OP_STP = 4'b0111;

  typedef enum logic {ASRC_PC, ASRC_IR} asrc_e;
  typedef enum logic [1:0] {BSRC_DATA, BSRC_ADDR, BSRC_ZERO} bsrc_e;

  typedef struct packed {
    logic a_en;
    logic b_inv;
    logic cin;
  } alu_fn_t;

  localparam alu_fn_t FN_ADD  = '{a_en: 1'b1, b_inv: 1'b0, cin: 1'b0};
  localparam alu_fn_t FN_SUB  = '{a_en: 1'b1, b_inv: 1'b1, cin: 1'b1};
  localparam alu_fn_t FN_PASS = '{a_en: 1'b0, b_inv: 1'b0, cin: 1'b0};
  localparam alu_fn_t FN_INC  = '{a_en: 1'b0, b_inv: 1'b0, cin: 1'b1};

  typedef struct packed {
    asrc_e   a_sel;
    bsrc_e   b_sel;
    alu_fn_t fn;
    logic    acc_ce;
    logic    pc_ce;
    logic    ir_ce;
    logic    acc_oe;
    logic    mem_req;
    logic    mem_rnw;
  } ctrl_t;

endpackage

// File: rtl/acc_alu.sv
module acc_alu
  import acc_cpu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  alu_fn_t      fn,
  output logic [W-1:0] result
);

  function automatic logic [W-1:0] alu_eval(
    input logic [W-1:0] a, input logic [W-1:0] b, input alu_fn_t f);
    logic [W-1:0] a_term;
    logic [W-1:0] b_term;
    a_term = f.a_en ? a : '0;
    b_term = f.b_inv ? ~b : b;
    return a_term + b_term + {{(W-1){1'b0}}, f.cin};
  endfunction

  assign result = alu_eval(op_a, op_b, fn);

endmodule

// File: rtl/acc_ctrl.sv
module acc_ctrl
  import acc_cpu_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [OP_W-1:0] opcode,
  input  logic            acc_neg,
  input  logic            acc_zero,
  output ctrl_t           ctl,
  output logic            fetch_phase,
  output logic            halted
);

  logic fetch_q;
  logic halted_q;
  logic is_data;
  logic is_jump;
  logic take_jump;
  logic halt_now;

  always_comb begin
    is_data   = (opcode == OP_LDA) || (opcode == OP_STO) ||
                (opcode == OP_ADD) || (opcode == OP_SUB);
    is_jump   = (opcode == OP_JMP) || (opcode == OP_JGE) || (opcode == OP_JNE);
    take_jump = (opcode == OP_JMP) ||
                ((opcode == OP_JGE) && !acc_neg) ||
                ((opcode == OP_JNE) && !acc_zero);
    halt_now  = rst_n && !fetch_q && !is_data && !is_jump;
  end

  always_comb begin
    ctl         = '0;
    ctl.a_sel   = ASRC_PC;
    ctl.b_sel   = BSRC_ADDR;
    ctl.fn      = FN_INC;
    ctl.mem_rnw = 1'b1;
    if (!rst_n) begin
      ctl.b_sel = BSRC_ZERO;
      ctl.fn    = FN_PASS;
    end else if (fetch_q) begin
      ctl.pc_ce   = 1'b1;
      ctl.ir_ce   = 1'b1;
      ctl.mem_req = 1'b1;
    end else if (is_data) begin
      ctl.a_sel   = ASRC_IR;
      ctl.b_sel   = BSRC_DATA;
      ctl.mem_req = 1'b1;
      unique case (opcode)
        OP_LDA: begin ctl.fn = FN_PASS; ctl.acc_ce = 1'b1; end
        OP_ADD: begin ctl.fn = FN_ADD;  ctl.acc_ce = 1'b1; end
        OP_SUB: begin ctl.fn = FN_SUB;  ctl.acc_ce = 1'b1; end
        default: begin
          ctl.fn      = FN_PASS;
          ctl.acc_oe  = 1'b1;
          ctl.mem_rnw = 1'b0;
        end
      endcase
    end else if (is_jump) begin
      ctl.a_sel   = take_jump ? ASRC_IR : ASRC_PC;
      ctl.pc_ce   = 1'b1;
      ctl.ir_ce   = 1'b1;
      ctl.mem_req = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fetch_q  <= 1'b1;
      halted_q <= 1'b0;
    end else begin
      if (fetch_q)      fetch_q <= 1'b0;
      else if (is_data) fetch_q <= 1'b1;
      if (halt_now)     halted_q <= 1'b1;
    end
  end

  assign fetch_phase = fetch_q;
  assign halted      = halted_q;

  AST_FETCH_THEN_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_q |=> !fetch_q); // R2
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    halted_q |=> (halted_q && !ctl.mem_req)); // R9

endmodule

// File: rtl/acc_regs.sv
module acc_regs #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_ce,
  input  logic              pc_ce,
  input  logic              ir_ce,
  input  logic [DATA_W-1:0] alu_y,
  input  logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] acc,
  output logic [ADDR_W-1:0] pc,
  output logic [DATA_W-1:0] ir
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0;
      pc  <= '0;
      ir  <= '0;
    end else begin
      if (acc_ce) acc <= alu_y;
      if (pc_ce)  pc  <= alu_y[ADDR_W-1:0];
      if (ir_ce)  ir  <= rdata;
    end
  end

endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  output logic [DATA_W-OP_W-1:0] mem_addr,
  input  logic [DATA_W-1:0]      mem_rdata,
  output logic [DATA_W-1:0]      mem_wdata,
  output logic                   mem_req,
  output logic                   mem_rnw,
  output logic                   halted
);

  localparam int ADDR_W = DATA_W - OP_W;

  ctrl_t             ctl;
  logic              fetch_phase;
  logic [DATA_W-1:0] acc;
  logic [ADDR_W-1:0] pc;
  logic [DATA_W-1:0] ir;
  logic [DATA_W-1:0] alu_b;
  logic [DATA_W-1:0] alu_y;
  logic [OP_W-1:0]   opcode;
  logic [ADDR_W-1:0] operand_s;
  logic              acc_zero;
  logic              acc_neg;

  assign opcode    = ir[DATA_W-1 -: OP_W];
  assign operand_s = ir[ADDR_W-1:0];
  assign acc_zero  = (acc == '0);
  assign acc_neg   = acc[DATA_W-1];

  acc_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .opcode      (opcode),
    .acc_neg     (acc_neg),
    .acc_zero    (acc_zero),
    .ctl         (ctl),
    .fetch_phase (fetch_phase),
    .halted      (halted)
  );

  assign mem_addr  = (ctl.a_sel == ASRC_IR) ? operand_s : pc;
  assign mem_req   = ctl.mem_req;
  assign mem_rnw   = ctl.mem_rnw;
  assign mem_wdata = ctl.acc_oe ? acc : '0;

  always_comb begin
    unique case (ctl.b_sel)
      BSRC_DATA: alu_b = mem_rdata;
      BSRC_ADDR: alu_b = {{OP_W{1'b0}}, mem_addr};
      default:   alu_b = '0;
    endcase
  end

  acc_alu #(.W(DATA_W)) u_alu (
    .op_a   (acc),
    .op_b   (alu_b),
    .fn     (ctl.fn),
    .result (alu_y)
  );

  acc_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .acc_ce (ctl.acc_ce),
    .pc_ce  (ctl.pc_ce),
    .ir_ce  (ctl.ir_ce),
    .alu_y  (alu_y),
    .rdata  (mem_rdata),
    .acc    (acc),
    .pc     (pc),
    .ir     (ir)
  );

  AST_FETCH_INC: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_phase |=> (pc == $past(mem_addr) + ADDR_W'(1))); // R2
  AST_STORE_ONLY_WDATA: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req && !mem_rnw) |-> (mem_wdata == '0)); // R5
  AST_JMP_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (!fetch_phase && opcode == OP_JMP) |-> (mem_addr == operand_s && mem_req)); // R6
  AST_JGE_NEG_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
    (!fetch_phase && opcode == OP_JGE && acc_neg) |-> (mem_addr == pc)); // R7
  AST_JNE_ZERO_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
    (!fetch_phase && opcode == OP_JNE && acc_zero) |-> (mem_addr == pc)); // R8
  AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> ($stable(pc) && $stable(acc))); // R9

endmodule

// File: tb/acc_cpu_test.sv
`timescale 1ns/1ps
module acc_cpu_test;

  logic        clk;
  logic        rst_n;
  logic [11:0] mem_addr;
  logic [15:0] mem_rdata;
  logic [15:0] mem_wdata;
  logic        mem_req;
  logic        mem_rnw;
  logic        halted;

  logic [15:0] mem [4096];
  int compared;
  int mismatched;

  acc_cpu uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_addr  (mem_addr),
    .mem_rdata (mem_rdata),
    .mem_wdata (mem_wdata),
    .mem_req   (mem_req),
    .mem_rnw   (mem_rnw),
    .halted    (halted)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  assign mem_rdata = mem[mem_addr];
  always @(posedge clk) if (rst_n && mem_req && !mem_rnw) mem[mem_addr] <= mem_wdata;

  function automatic logic [15:0] ins(input logic [3:0] op, input logic [11:0] s);
    return {op, s};
  endfunction

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 4096; i++) mem[i] = 16'h0000;
  endtask

  // Resets, releases at a falling edge, counts edges until halted.
  task automatic run_prog(output int edges, output int leaks);
    edges = 0;
    leaks = 0;
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < 500; k++) begin
      @(posedge clk);
      @(negedge clk);
      edges++;
      if (!(mem_req && !mem_rnw) && mem_wdata !== 16'h0000) leaks++;
      if (halted) break;
    end
  endtask

  task automatic t_arith();
    int n, lk;
    clear_mem();
    mem[12'h100] = 16'h1234; mem[12'h101] = 16'h0F0F; mem[12'h102] = 16'h2000;
    mem[0] = ins(4'h0, 12'h100);
    mem[1] = ins(4'h2, 12'h101);
    mem[2] = ins(4'h1, 12'h200);
    mem[3] = ins(4'h3, 12'h102);
    mem[4] = ins(4'h1, 12'h201);
    mem[5] = ins(4'h7, 12'h000);
    run_prog(n, lk);
    check("R3 R4 add result", 32'(mem[12'h200]), 32'h2143);
    check("R4 sub result", 32'(mem[12'h201]), 32'h0143);
    check("R2 cycle count data program", n, 12);
    check("R5 wdata zero outside store", lk, 0);
  endtask

  task automatic t_wrap_arith();
    int n, lk;
    clear_mem();
    mem[12'h100] = 16'hFFFF; mem[12'h101] = 16'h0002; mem[12'h102] = 16'h0003;
    mem[0] = ins(4'h0, 12'h100);
    mem[1] = ins(4'h2, 12'h101);
    mem[2] = ins(4'h1, 12'h200);
    mem[3] = ins(4'h3, 12'h102);
    mem[4] = ins(4'h1, 12'h201);
    mem[5] = ins(4'h7, 12'h000);
    run_prog(n, lk);
    check("R4 add modulo", 32'(mem[12'h200]), 32'h0001);
    check("R4 sub borrow modulo", 32'(mem[12'h201]), 32'hFFFE);
  endtask

  task automatic t_reset();
    clear_mem();
    mem[0] = ins(4'h7, 12'h000);
    rst_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R1 req low in reset", 32'(mem_req), 0);
    check("R1 halted clear in reset", 32'(halted), 0);
    check("R1 wdata zero in reset", 32'(mem_wdata), 0);
    rst_n = 1'b1;
    #1;
    check("R1 first address", 32'(mem_addr), 0);
    check("R1 first access is read", 32'({mem_req, mem_rnw}), 32'h3);
    @(posedge clk); @(negedge clk);
    check("R2 halt not before execute", 32'(halted), 0);
    @(posedge clk); @(negedge clk);
    check("R9 halt opcode 0111", 32'(halted), 1);
  endtask

  task automatic t_jmp();
    int n, lk;
    clear_mem();
    mem[12'h100] = 16'hA5A5; mem[12'h201] = 16'hBEEF;
    mem[0] = ins(4'h4, 12'h050);
    mem[1] = ins(4'h1, 12'h201);
    mem[12'h050] = ins(4'h0, 12'h100);
    mem[12'h051] = ins(4'h1, 12'h200);
    mem[12'h052] = ins(4'h7, 12'h000);
    run_prog(n, lk);
    check("R6 target executed", 32'(mem[12'h200]), 32'hA5A5);
    check("R6 fall-through skipped", 32'(mem[12'h201]), 32'hBEEF);
    check("R6 R2 jump single cycle", n, 7);
  endtask

  task automatic t_jge();
    int n, lk;
    clear_mem();
    mem[12'h100] = 16'h7FFF; mem[12'h101] = 16'h8000; mem[12'h102] = 16'h0000;
    mem[12'h201] = 16'hBEEF; mem[12'h202] = 16'hDEAD;
    mem[0] = ins(4'h0, 12'h100);
    mem[1] = ins(4'h5, 12'h010);
    mem[2] = ins(4'h7, 12'h000);
    mem[12'h010] = ins(4'h0, 12'h101);
    mem[12'h011] = ins(4'h5, 12'h030);
    mem[12'h012] = ins(4'h1, 12'h200);
    mem[12'h013] = ins(4'h0, 12'h102);
    mem[12'h014] = ins(4'h5, 12'h020);
    mem[12'h015] = ins(4'h7, 12'h000);
    mem[12'h020] = ins(4'h1, 12'h201);
    mem[12'h021] = ins(4'h7, 12'h000);
    mem[12'h030] = ins(4'h1, 12'h202);
    mem[12'h031] = ins(4'h7, 12'h000);
    run_prog(n, lk);
    check("R7 negative falls through", 32'(mem[12'h200]), 32'h8000);
    check("R7 zero takes jump", 32'(mem[12'h201]), 32'h0000);
    check("R7 negative target not reached", 32'(mem[12'h202]), 32'hDEAD);
    check("R7 cycle count", n, 15);
  endtask

  task automatic t_jne();
    int n, lk;
    clear_mem();
    mem[12'h100] = 16'h0000; mem[12'h101] = 16'h0005; mem[12'h201] = 16'hCAFE;
    mem[0] = ins(4'h0, 12'h100);
    mem[1] = ins(4'h6, 12'h030);
    mem[2] = ins(4'h0, 12'h101);
    mem[3] = ins(4'h6, 12'h020);
    mem[4] = ins(4'h7, 12'h000);
    mem[12'h020] = ins(4'h1, 12'h200);
    mem[12'h021] = ins(4'h7, 12'h000);
    mem[12'h030] = ins(4'h1, 12'h201);
    mem[12'h031] = ins(4'h7, 12'h000);
    run_prog(n, lk);
    check("R8 nonzero takes jump", 32'(mem[12'h200]), 32'h0005);
    check("R8 zero does not jump", 32'(mem[12'h201]), 32'hCAFE);
    check("R8 cycle count", n, 10);
  endtask

  task automatic t_pc_wrap();
    int n, lk;
    clear_mem();
    mem[12'h100] = 16'h55AA;
    mem[0] = ins(4'h6, 12'h010);
    mem[1] = ins(4'h0, 12'h100);
    mem[2] = ins(4'h4, 12'hFFF);
    mem[12'hFFF] = ins(4'h1, 12'h200);
    mem[12'h010] = ins(4'h7, 12'h000);
    run_prog(n, lk);
    check("R10 store at 0xFFF done", 32'(mem[12'h200]), 32'h55AA);
    check("R10 continues at 0x000", n, 9);
    check("R10 halted after wrap", 32'(halted), 1);
  endtask

  task automatic t_halt();
    int n, lk, bad_req, bad_halt;
    clear_mem();
    mem[12'h100] = 16'h4321; mem[12'h123] = 16'h7777;
    mem[0] = ins(4'h0, 12'h100);
    mem[1] = ins(4'h1, 12'h200);
    mem[2] = ins(4'hA, 12'h123);
    run_prog(n, lk);
    check("R9 undefined opcode halts", n, 6);
    bad_req = 0;
    bad_halt = 0;
    for (int k = 0; k < 20; k++) begin
      @(posedge clk); @(negedge clk);
      if (mem_req) bad_req++;
      if (!halted) bad_halt++;
    end
    check("R9 no request while halted", bad_req, 0);
    check("R9 halted held", bad_halt, 0);
    check("R9 operand word untouched", 32'(mem[12'h123]), 32'h7777);
    check("R5 store before halt", 32'(mem[12'h200]), 32'h4321);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    compared = 0;
    mismatched = 0;
    rst_n = 1'b0;
    clear_mem();
    t_arith();
    t_reset();
    t_wrap_arith();
    t_jmp();
    t_jge();
    t_jne();
    t_pc_wrap();
    t_halt();
    summary();
    $finish;
  end

endmodule